// File: doc/BRIEF.md
# Paged Register-Mapped GPIO Port

This block is an eight-pin general-purpose I/O port on a special-function-register bus that is split into pages. It holds two registers: a port data latch and an output-mode register. Each pin is driven through its own output-value and output-enable signals, plus a weak pull-up enable. A mode bit of 1 makes its pin push-pull, so the pin always drives the latch bit. A mode bit of 0 makes its pin open-drain, so the pin drives low for a 0 and is released for a 1. The pull-up works on released pins only, and one global input can switch it off for all pins.

The registers respond only while the bus page input holds the port's page number. A read of the data register normally returns the pin levels, after they pass through a two-flop synchroniser. When the CPU flags the read as the read phase of a read-modify-write, the read returns the latch instead. Writes can replace a whole register, or they can set one bit of the addressed register to a given value.

Every bus access completes in one cycle. There is no back-pressure: the block never stalls the bus, and the bus has no ready signal. Read data comes with a one-cycle-later valid strobe.

Top module: `gpio_sfr_port`

## Requirements
- R1: After reset the data latch is 0xFF and the mode register is 0x00. All pins are released (`pin_oe` = 0x00), and `pullup_en` = 0xFF while `pullup_dis` is 0.
- R2: A read (`sfr_rd`) of the data register at address 0x90 with `sfr_rmw` = 0 sets `rd_valid` in the next cycle. `rd_data` then holds the `pin_in` value that was present two clock edges before the read's edge, so a pin change made in the cycle of the read is not yet seen.
- R3: A data-register read with `sfr_rmw` = 1 returns the data latch, whatever the pins show.
- R4: A pin whose mode bit is 1 has `pin_oe` = 1, and `pin_out` equals its latch bit.
- R5: A pin whose mode bit is 0 has `pin_oe` = 1 with `pin_out` = 0 when its latch bit is 0. It has `pin_oe` = 0 when its latch bit is 1.
- R6: `pullup_en[i]` is 1 exactly when pin i is released and `pullup_dis` is 0.
- R7: Writes are ignored unless `sfr_page` = 0x0F. A read on any other page gives `rd_valid` = 0 and `rd_data` = 0x00 in the next cycle.
- R8: The mode register is at address 0xA7 and reads back exactly what was written.
- R9: A byte write (`sfr_wr`) replaces all eight bits of the addressed register, and the result shows on the pins in the next cycle.
- R10: A bit write (`sfr_bit_wr`) sets bit `sfr_bit_sel` of the addressed register to `sfr_bit_val` and leaves the other seven bits unchanged.
- R11: An access to any address other than 0x90 or 0xA7 changes no register, and a read there gives `rd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_page | input | 8 | Current bus page |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_bit_wr | input | 1 | Single-bit write strobe |
| sfr_bit_sel | input | 3 | Bit index for a bit write |
| sfr_bit_val | input | 1 | Value for a bit write |
| sfr_rd | input | 1 | Read strobe |
| sfr_rmw | input | 1 | Read is the read phase of a read-modify-write |
| rd_data | output | 8 | Read data, one cycle after the read |
| rd_valid | output | 1 | Read hit this block |
| pullup_dis | input | 1 | Global weak pull-up disable |
| pin_in | input | 8 | Pin levels as seen at the pads |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |
| pullup_en | output | 8 | Per-pin weak pull-up enable |

## Verification
The pins are driven from a bench-side pad model. That model combines the port's drive, a pull-up, a floating level of 0, and an external device that can pull chosen pins low. With this setup, normal reads and read-modify-write reads return visibly different values on shared open-drain pins. Mixed mode patterns, such as the low nibble push-pull and the high nibble open-drain, separate push-pull drive from open-drain drive in a single byte. Turning the pull-up off separates a released pin that is pulled up from one left floating. A pin change made in the same cycle as a read tells the two-flop synchroniser delay apart from a shorter or longer path. Writes and reads that go off-page or to an unmapped address show whether the decode leaks.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_MODE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '1;
    else        stage[0] <= async_in;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '1;
      else        stage[s] <= stage[s-1];
    end
  end

  assign sync_out = stage[DEPTH-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int         W         = 8,
  parameter int         SELW      = $clog2(W),
  parameter logic [7:0] PAGE      = 8'h0F,
  parameter logic [7:0] DATA_ADDR = 8'h90,
  parameter logic [7:0] MODE_ADDR = 8'hA7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      page,
  input  logic [7:0]      addr,
  input  logic            wr,
  input  logic [W-1:0]    wdata,
  input  logic            bit_wr,
  input  logic [SELW-1:0] bit_sel,
  input  logic            bit_val,
  output logic [W-1:0]    latch,
  output logic [W-1:0]    mode,
  output reg_sel_e        sel
);
  always_comb begin
    sel = SEL_NONE;
    if (page == PAGE) begin
      if (addr == DATA_ADDR)      sel = SEL_DATA;
      else if (addr == MODE_ADDR) sel = SEL_MODE;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_hit;
    assign bit_hit = bit_wr && (bit_sel == SELW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latch[i] <= 1'b1;
        mode[i]  <= 1'b0;
      end else begin
        if (sel == SEL_DATA) begin
          if (wr)           latch[i] <= wdata[i];
          else if (bit_hit) latch[i] <= bit_val;
        end
        if (sel == SEL_MODE) begin
          if (wr)           mode[i] <= wdata[i];
          else if (bit_hit) mode[i] <= bit_val;
        end
      end
    end
  end

  // R7: off-page writes leave both registers alone
  a_r7_offpage_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr || bit_wr) && page != PAGE) |=> ($stable(latch) && $stable(mode)));

  // R10: a bit write flips at most one latch bit
  a_r10_bit_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && !wr) |=> ($countones(latch ^ $past(latch)) <= 1));

  // R11: unmapped address changes nothing
  a_r11_unmapped_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr || bit_wr) && addr != DATA_ADDR && addr != MODE_ADDR)
      |=> ($stable(latch) && $stable(mode)));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] mode,
  input  logic         pullup_dis,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pullup_en
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      pin_out[i]   = latch[i];
      pin_oe[i]    = mode[i] | ~latch[i];
      pullup_en[i] = ~pin_oe[i] & ~pullup_dis;
    end
  end

  // R6: a driven pin never has the pull-up on
  a_r6_pullup_only_released: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_en & pin_oe) == '0);

  // R5: an enabled open-drain pin only ever drives low
  a_r5_od_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~mode & pin_out) == '0);
endmodule

// File: rtl/gpio_sfr_port.sv
module gpio_sfr_port
  import gpio_port_pkg::*;
#(
  parameter int         W         = 8,
  parameter int         SYNC      = 2,
  parameter logic [7:0] PAGE      = 8'h0F,
  parameter logic [7:0] DATA_ADDR = 8'h90,
  parameter logic [7:0] MODE_ADDR = 8'hA7,
  localparam int        SELW      = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      sfr_page,
  input  logic [7:0]      sfr_addr,
  input  logic            sfr_wr,
  input  logic [W-1:0]    sfr_wdata,
  input  logic            sfr_bit_wr,
  input  logic [SELW-1:0] sfr_bit_sel,
  input  logic            sfr_bit_val,
  input  logic            sfr_rd,
  input  logic            sfr_rmw,
  output logic [W-1:0]    rd_data,
  output logic            rd_valid,
  input  logic            pullup_dis,
  input  logic [W-1:0]    pin_in,
  output logic [W-1:0]    pin_out,
  output logic [W-1:0]    pin_oe,
  output logic [W-1:0]    pullup_en
);
  logic [W-1:0] latch;
  logic [W-1:0] mode;
  logic [W-1:0] pin_sync;
  reg_sel_e     sel;

  gpio_port_regs #(
    .W(W), .SELW(SELW), .PAGE(PAGE), .DATA_ADDR(DATA_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .page(sfr_page), .addr(sfr_addr),
    .wr(sfr_wr), .wdata(sfr_wdata), .bit_wr(sfr_bit_wr),
    .bit_sel(sfr_bit_sel), .bit_val(sfr_bit_val),
    .latch(latch), .mode(mode), .sel(sel)
  );

  gpio_pin_sync #(.W(W), .DEPTH(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_pin_drive #(.W(W)) u_drive (
    .clk(clk), .rst_n(rst_n), .latch(latch), .mode(mode),
    .pullup_dis(pullup_dis), .pin_out(pin_out), .pin_oe(pin_oe),
    .pullup_en(pullup_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      if (sfr_rd) begin
        unique case (sel)
          SEL_DATA: begin
            rd_data  <= sfr_rmw ? latch : pin_sync;
            rd_valid <= 1'b1;
          end
          SEL_MODE: begin
            rd_data  <= mode;
            rd_valid <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R3: read-modify-write read returns the latch
  a_r3_rmw_returns_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && sfr_rmw && sfr_page == PAGE && sfr_addr == DATA_ADDR)
      |=> (rd_valid && rd_data == $past(pin_out)));

  // R7: off-page read is silent
  a_r7_offpage_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && sfr_page != PAGE) |=> (!rd_valid && rd_data == '0));

  // R2: valid only follows a read strobe
  a_r2_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(sfr_rd));
endmodule

// File: tb/gpio_sfr_port_test.sv
module gpio_sfr_port_test;
  localparam int PERIOD = 10;
  localparam int W = 8;
  localparam logic [7:0] PG = 8'h0F, DADDR = 8'h90, MADDR = 8'hA7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sfr_page = PG, sfr_addr = 8'h00;
  logic sfr_wr = 0, sfr_bit_wr = 0, sfr_bit_val = 0, sfr_rd = 0, sfr_rmw = 0;
  logic [W-1:0] sfr_wdata = '0;
  logic [2:0] sfr_bit_sel = '0;
  logic pullup_dis = 0;
  logic [W-1:0] ext_low = '0;
  logic [W-1:0] rd_data, pin_out, pin_oe, pullup_en, pin_in;
  logic rd_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_sfr_port uut (
    .clk(clk), .rst_n(rst_n), .sfr_page(sfr_page), .sfr_addr(sfr_addr),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_bit_wr(sfr_bit_wr),
    .sfr_bit_sel(sfr_bit_sel), .sfr_bit_val(sfr_bit_val), .sfr_rd(sfr_rd),
    .sfr_rmw(sfr_rmw), .rd_data(rd_data), .rd_valid(rd_valid),
    .pullup_dis(pullup_dis), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pullup_en(pullup_en)
  );

  // pad model: driven > external pull-low > pull-up > floats to 0
  always_comb
    for (int i = 0; i < W; i++)
      pin_in[i] = pin_oe[i] ? pin_out[i] : (ext_low[i] ? 1'b0 : pullup_en[i]);

  // behavioural reference model
  logic [W-1:0] m_latch, m_mode, m_rdata;
  logic m_valid;
  logic [W-1:0] hist [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch = '1; m_mode = '0; m_rdata = '0; m_valid = 0;
      hist = {8'hFF, 8'hFF};
    end else begin
      logic [W-1:0] old_pin;
      old_pin = hist[0];
      hist.pop_front();
      hist.push_back(pin_in);
      m_valid = 0; m_rdata = '0;
      if (sfr_rd && sfr_page == PG && sfr_addr == DADDR) begin
        m_valid = 1; m_rdata = sfr_rmw ? m_latch : old_pin;
      end else if (sfr_rd && sfr_page == PG && sfr_addr == MADDR) begin
        m_valid = 1; m_rdata = m_mode;
      end
      if (sfr_page == PG && sfr_addr == DADDR) begin
        if (sfr_wr) m_latch = sfr_wdata;
        else if (sfr_bit_wr) m_latch[sfr_bit_sel] = sfr_bit_val;
      end
      if (sfr_page == PG && sfr_addr == MADDR) begin
        if (sfr_wr) m_mode = sfr_wdata;
        else if (sfr_bit_wr) m_mode[sfr_bit_sel] = sfr_bit_val;
      end
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    check("R4 pin_out", pin_out, m_latch);
    check("R5 pin_oe", pin_oe, m_mode | ~m_latch);
    check("R6 pullup_en", pullup_en, ~(m_mode | ~m_latch) & {W{~pullup_dis}});
    check("R2 rd_valid", {7'd0, rd_valid}, {7'd0, m_valid});
    check("R2 rd_data", rd_data, m_rdata);
  end

  task automatic idle();
    sfr_wr = 0; sfr_bit_wr = 0; sfr_rd = 0; sfr_rmw = 0; sfr_page = PG;
  endtask

  task automatic wr_byte(input logic [7:0] pg, input logic [7:0] a, input logic [7:0] d);
    sfr_page = pg; sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    @(negedge clk); idle();
  endtask

  task automatic wr_bit(input logic [7:0] a, input int b, input logic v);
    sfr_addr = a; sfr_bit_sel = 3'(b); sfr_bit_val = v; sfr_bit_wr = 1;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [7:0] pg, input logic [7:0] a, input logic rmw,
                    output logic [7:0] d, output logic v);
    sfr_page = pg; sfr_addr = a; sfr_rmw = rmw; sfr_rd = 1;
    @(negedge clk); idle();
    d = rd_data; v = rd_valid;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", pin_oe, 8'h00);
    check("R1 pullup", pullup_en, 8'hFF);
    rd(PG, MADDR, 0, d, v);
    check("R1 mode reset", d, 8'h00);
    rd(PG, DADDR, 1, d, v);
    check("R1 latch reset", d, 8'hFF);

    // R8 R9: mixed mode pattern
    wr_byte(PG, MADDR, 8'h0F);
    wr_byte(PG, DADDR, 8'h55);
    check("R9 pin_out", pin_out, 8'h55);
    check("R4 R5 oe", pin_oe, 8'hAF);
    rd(PG, MADDR, 0, d, v);
    check("R8 mode readback", d, 8'h0F);

    // R2 R3 shared wire pulled low externally on released bit 6
    ext_low = 8'h40;
    repeat (3) @(negedge clk);
    rd(PG, DADDR, 0, d, v);
    check("R2 pin read", d, 8'h15);
    rd(PG, DADDR, 1, d, v);
    check("R3 rmw read", d, 8'h55);

    // R2 synchroniser delay: change in the read cycle not yet seen
    ext_low = 8'h10;
    rd(PG, DADDR, 0, d, v);
    check("R2 old level", d, 8'h15);
    repeat (2) @(negedge clk);
    rd(PG, DADDR, 0, d, v);
    check("R2 new level", d, 8'h45);
    ext_low = 8'h00;

    // R6 pull-up disabled: released pins float low
    pullup_dis = 1;
    @(negedge clk);
    check("R6 pullup off", pullup_en, 8'h00);
    repeat (3) @(negedge clk);
    rd(PG, DADDR, 0, d, v);
    check("R6 floating read", d, 8'h05);
    pullup_dis = 0;

    // R7 off-page
    wr_byte(8'h00, DADDR, 8'h00);
    check("R7 write ignored", pin_out, 8'h55);
    rd(8'h03, DADDR, 0, d, v);
    check("R7 read valid", {7'd0, v}, 8'h00);
    check("R7 read data", d, 8'h00);

    // R10 bit writes
    wr_bit(DADDR, 1, 1'b1);
    check("R10 bit set", pin_out, 8'h57);
    wr_bit(DADDR, 6, 1'b0);
    check("R10 bit clear", pin_out, 8'h17);
    wr_bit(MADDR, 7, 1'b1);
    rd(PG, MADDR, 0, d, v);
    check("R10 mode bit", d, 8'h8F);

    // R11 unmapped address
    wr_byte(PG, 8'h91, 8'h00);
    check("R11 write ignored", pin_out, 8'h17);
    rd(PG, 8'hA8, 0, d, v);
    check("R11 read valid", {7'd0, v}, 8'h00);

    // R9 all push-pull
    wr_byte(PG, MADDR, 8'hFF);
    wr_byte(PG, DADDR, 8'hC3);
    check("R9 push-pull oe", pin_oe, 8'hFF);
    check("R4 push-pull out", pin_out, 8'hC3);
    repeat (3) @(negedge clk);
    rd(PG, DADDR, 0, d, v);
    check("R2 push-pull pins", d, 8'hC3);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule